// File: doc/BRIEF.md
# Edge-Serviced Watchdog with Floating-Input Disable

This block watches a single service line from a processor. Any change of level on that line, rising or falling, restarts a cycle-count timer. If the timer runs a full timeout period with no service change, the active-low watchdog output drops. The output is also pulled low at once, with no clock delay, whenever the supply monitor reports a low supply. The timer is held at zero while the neighbouring reset controller asserts its reset condition. It starts counting only after that condition clears.

The watchdog can be turned off by leaving the service line undriven. The block drives two pull-enable outputs for external weak pull devices. Over each pattern period of `TIMEOUT_CYC` cycles it asks for a pull to ground during the first seven eighths and a pull to supply during the last eighth. The sensed input is synchronised and compared with a copy of the pull request that has passed through a pipeline of the same length. A full period in which the sensed level only follows the pulls marks the line as floating. While it is floating, the watchdog is disabled and never times out. Edges that the pull pattern itself causes are never treated as service.

Top module: `wdt_float_guard`

## Requirements
- R1: After the flop reset releases, `wdt_out_n` is 1 and stays 1 while `sys_rst_act` is held, however long the hold lasts.
- R2: A rising or a falling change of `wdt_in`, held for at least one clock, restarts the timer. Changes spaced less than `TIMEOUT_CYC` cycles apart keep `wdt_out_n` at 1.
- R3: If no service change is seen for `TIMEOUT_CYC` cycles, `wdt_out_n` goes to 0. This happens within 2 synchroniser cycles plus one register cycle after the count completes.
- R4: The timer stays at zero while `sys_rst_act` is 1. It counts from zero once `sys_rst_act` returns to 0, so a timeout follows about `TIMEOUT_CYC` cycles after release.
- R5: While `supply_low` is 1, `wdt_out_n` is 0 in the same cycle, whatever the timer holds.
- R6: `pull_lo_en` and `pull_hi_en` are always complementary. Over any `TIMEOUT_CYC` consecutive cycles, `pull_hi_en` is 1 for exactly `TIMEOUT_CYC/8` of them, all of them at the end of the pattern period.
- R7: When `wdt_in` only follows `pull_hi_en` for a full pattern period, the line counts as floating. From then on `wdt_out_n` stays 1 and no timeout occurs.
- R8: A sensed level that departs from the pull pattern clears the floating state, and normal timing then resumes.
- R9: A service pulse one clock cycle wide restarts the timer.
- R10: After a timeout, `wdt_out_n` returns to 1 on the next genuine service change, or when `sys_rst_act` is asserted. The timer then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low flop reset |
| sys_rst_act | input | 1 | Reset condition from the reset controller; holds the timer at zero |
| supply_low | input | 1 | Supply below threshold; forces the output active |
| wdt_in | input | 1 | Raw service line, asynchronous |
| pull_lo_en | output | 1 | Enable for the weak pull to ground |
| pull_hi_en | output | 1 | Enable for the weak pull to supply |
| wdt_out_n | output | 1 | Active-low watchdog output |

## Verification
A wrong timer count shows at `wdt_out_n` as a drop that comes early or late, measured from the last service change. A missed service edge shows as a drop within one timeout period. A floating state that sets by mistake hides every timeout, so the output stays high more than two periods after service stops. A floating state that never sets lets an undriven line time out within about one period. Errors in the pull pattern show in the very next period as a wrong count of high-pull cycles, or as both enables at the same level.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned DEF_TIMEOUT = 256;
    localparam int unsigned DEF_SYNC    = 2;

    // Start position of the high-pull phase: the last eighth of the period.
    function automatic int unsigned hi_phase_start(input int unsigned period);
        return period - (period / 8);
    endfunction

endpackage

// File: rtl/wdt_pull_gen.sv
module wdt_pull_gen #(
    parameter int unsigned PERIOD = 256,
    parameter int unsigned CW     = $clog2(PERIOD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic pull_hi
);
    import wdt_pkg::*;

    localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HI_FROM = CW'(hi_phase_start(PERIOD));

    logic [CW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign pull_hi = (phase_q >= HI_FROM);

endmodule

// File: rtl/wdt_in_sync.sv
module wdt_in_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic pull_hi,
    output logic lvl,
    output logic lvl_prev,
    output logic exp_lvl,
    output logic exp_prev
);
    // One extra stage past the synchroniser holds the previous level.
    logic [STAGES:0] lv_d, lv_q;
    logic [STAGES:0] ex_d, ex_q;

    always_comb begin
        lv_d = {lv_q[STAGES-1:0], raw_in};
        ex_d = {ex_q[STAGES-1:0], pull_hi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lv_q <= '0;
            ex_q <= '0;
        end else begin
            lv_q <= lv_d;
            ex_q <= ex_d;
        end
    end

    assign lvl      = lv_q[STAGES-1];
    assign lvl_prev = lv_q[STAGES];
    assign exp_lvl  = ex_q[STAGES-1];
    assign exp_prev = ex_q[STAGES];

endmodule

// File: rtl/wdt_float_det.sv
module wdt_float_det #(
    parameter int unsigned PERIOD = 256,
    parameter int unsigned CW     = $clog2(PERIOD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic exp_lvl,
    output logic floating
);
    localparam logic [CW-1:0] FULL = CW'(PERIOD);

    logic [CW-1:0] match_d, match_q;

    always_comb begin
        if (lvl != exp_lvl)      match_d = '0;
        else if (match_q < FULL) match_d = match_q + 1'b1;
        else                     match_d = match_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= '0;
        else        match_q <= match_d;
    end

    assign floating = (match_q == FULL);

endmodule

// File: rtl/wdt_float_guard.sv
module wdt_float_guard #(
    parameter int unsigned TIMEOUT_CYC = wdt_pkg::DEF_TIMEOUT,
    parameter int unsigned SYNC_STAGES = wdt_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_rst_act,
    input  logic supply_low,
    input  logic wdt_in,
    output logic pull_lo_en,
    output logic pull_hi_en,
    output logic wdt_out_n
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          expired;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    logic pull_hi;
    logic lvl, lvl_prev, exp_lvl, exp_prev;
    logic floating;
    logic any_edge, pat_edge, svc_edge;

    wdt_pull_gen #(.PERIOD(TIMEOUT_CYC), .CW(CW)) u_pull (
        .clk     (clk),
        .rst_n   (rst_n),
        .pull_hi (pull_hi)
    );

    wdt_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (wdt_in),
        .pull_hi  (pull_hi),
        .lvl      (lvl),
        .lvl_prev (lvl_prev),
        .exp_lvl  (exp_lvl),
        .exp_prev (exp_prev)
    );

    wdt_float_det #(.PERIOD(TIMEOUT_CYC), .CW(CW)) u_float (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl),
        .exp_lvl  (exp_lvl),
        .floating (floating)
    );

    // A change that lands on a pattern boundary, in the pattern's direction,
    // is attributed to the pulls and never counts as service.
    always_comb begin
        any_edge = (lvl != lvl_prev);
        pat_edge = any_edge && (exp_lvl != exp_prev) && (lvl == exp_lvl);
        svc_edge = any_edge && !pat_edge;
    end

    always_comb begin
        tmr_d = tmr_q;
        if (sys_rst_act || floating || svc_edge) begin
            tmr_d.cnt     = '0;
            tmr_d.expired = 1'b0;
        end else if (!tmr_q.expired) begin
            if (tmr_q.cnt == LIMIT) begin
                tmr_d.cnt     = '0;
                tmr_d.expired = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign pull_hi_en = pull_hi;
    assign pull_lo_en = !pull_hi;
    assign wdt_out_n  = !(tmr_q.expired || supply_low);

endmodule

// File: rtl/wdt_float_guard_chk.sv
module wdt_float_guard_chk #(
    parameter int unsigned CW = 9,
    parameter int unsigned TIMEOUT_CYC = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sys_rst_act,
    input logic          supply_low,
    input logic          pull_lo_en,
    input logic          pull_hi_en,
    input logic          wdt_out_n,
    input logic          floating,
    input logic          expired,
    input logic [CW-1:0] cnt
);
    AST_LOWSUP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !wdt_out_n); // R5

    AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        pull_lo_en != pull_hi_en); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sys_rst_act) && sys_rst_act && !supply_low) |-> wdt_out_n); // R10

    AST_CNT_HELD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_act |=> (cnt == '0)); // R4

    AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> ($past(cnt) == CW'(TIMEOUT_CYC - 1))); // R3

    AST_FLOAT_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (floating && $past(floating)) |-> !expired); // R7

endmodule

bind wdt_float_guard wdt_float_guard_chk #(.CW(CW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst_act (sys_rst_act),
    .supply_low  (supply_low),
    .pull_lo_en  (pull_lo_en),
    .pull_hi_en  (pull_hi_en),
    .wdt_out_n   (wdt_out_n),
    .floating    (floating),
    .expired     (tmr_q.expired),
    .cnt         (tmr_q.cnt)
);

// File: tb/tb_wdt_float_guard.sv
module tb_wdt_float_guard;
    localparam int CLK_PERIOD = 10;
    localparam int T = 256;

    typedef struct packed {
        logic        ls;
        logic        tog;
        logic [15:0] wt;
        logic        exp;
        logic [7:0]  req;
    } row_t;

    localparam row_t ROWS [7] = '{
        '{ls:1'b0, tog:1'b1, wt:16'd10,      exp:1'b1, req:8'd2},  // R2 service edge
        '{ls:1'b0, tog:1'b0, wt:16'(T + 4),  exp:1'b0, req:8'd3},  // R3 silence -> timeout
        '{ls:1'b0, tog:1'b1, wt:16'd4,       exp:1'b1, req:8'd10}, // R10 edge clears
        '{ls:1'b1, tog:1'b0, wt:16'd1,       exp:1'b0, req:8'd5},  // R5 low supply
        '{ls:1'b0, tog:1'b1, wt:16'(T - 10), exp:1'b1, req:8'd2},  // R2
        '{ls:1'b0, tog:1'b1, wt:16'(T - 10), exp:1'b1, req:8'd2},  // R2 other direction
        '{ls:1'b0, tog:1'b0, wt:16'd20,      exp:1'b0, req:8'd3}   // R3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_rst_act = 1'b1;
    logic supply_low = 1'b0;
    logic drv = 1'b0;
    logic float_mode = 1'b0;
    logic wdt_in;
    logic pull_lo_en, pull_hi_en, wdt_out_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    assign wdt_in = float_mode ? pull_hi_en : drv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_float_guard #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sys_rst_act (sys_rst_act),
        .supply_low  (supply_low),
        .wdt_in      (wdt_in),
        .pull_lo_en  (pull_lo_en),
        .pull_hi_en  (pull_hi_en),
        .wdt_out_n   (wdt_out_n)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at cycle %0d", req, got, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        while (!done && cyc < 150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            finish_run();
        end
    end

    initial begin
        int hi_cnt;
        bit excl_ok;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        check(wdt_out_n, 1'b1, "R1 out high after reset");

        wait_cyc(3 * T);
        check(wdt_out_n, 1'b1, "R1 held high during long reset hold");

        // R6: pull pattern over one full period
        hi_cnt = 0;
        excl_ok = 1'b1;
        for (int i = 0; i < T; i++) begin
            if (pull_hi_en) hi_cnt++;
            if (pull_hi_en == pull_lo_en) excl_ok = 1'b0;
            @(negedge clk);
        end
        n_chk++;
        if (hi_cnt != T / 8) begin
            n_fail++;
            $display("FAIL R6 high-pull count: got %0d expected %0d", hi_cnt, T / 8);
        end
        check(excl_ok, 1'b1, "R6 pull enables complementary");

        // R4: timer starts only after release
        sys_rst_act = 1'b0;
        wait_cyc(T - 10);
        check(wdt_out_n, 1'b1, "R4 no timeout before full count after release");
        wait_cyc(14);
        check(wdt_out_n, 1'b0, "R4 timeout after release");

        // R10: reset clears an expired watchdog
        sys_rst_act = 1'b1;
        wait_cyc(2);
        check(wdt_out_n, 1'b1, "R10 reset clears timeout");
        sys_rst_act = 1'b0;

        for (int r = 0; r < 7; r++) begin
            supply_low = ROWS[r].ls;
            if (ROWS[r].tog) drv = ~drv;
            wait_cyc(int'(ROWS[r].wt));
            check(wdt_out_n, ROWS[r].exp, $sformatf("R%0d table row %0d", ROWS[r].req, r));
        end

        // R9: single-cycle pulse restarts the timer
        drv = ~drv;
        wait_cyc(T - 20);
        drv = ~drv;
        wait_cyc(1);
        drv = ~drv;
        wait_cyc(30);
        check(wdt_out_n, 1'b1, "R9 one-cycle pulse serviced");
        wait_cyc(T);
        check(wdt_out_n, 1'b0, "R9 timeout after pulse");

        // R7: floating line disables the watchdog
        float_mode = 1'b1;
        wait_cyc(2 * T + 10);
        check(wdt_out_n, 1'b1, "R7 floating input disables");
        for (int k = 0; k < 6; k++) begin
            wait_cyc(T / 2);
            check(wdt_out_n, 1'b1, "R7 stays disabled while floating");
        end

        // R8: driving the line again ends the floating state
        drv = 1'b0;
        float_mode = 1'b0;
        wait_cyc(2 * T + 10);
        check(wdt_out_n, 1'b0, "R8 timeout resumes after driving");

        done = 1'b1;
        finish_run();
    end

endmodule